// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between the integer core and a word-wide data memory. It takes one decoded instruction word together with the two source register values and the current program counter. If the word belongs to the load or store group, the unit works out the effective address and forces it to the access size. For stores it builds byte-lane enables and write data that is copied across the lanes. For loads it picks the returned byte or halfword out of the word and extends it to 32 bits.

Two load sub-ops never touch memory: the upper-immediate form and the pc-relative upper-immediate form. Both produce their result one cycle after acceptance. A further sub-op in each of the two groups goes to a separate I/O port instead of memory. That port has the same request/valid handshake as the memory port.

Only one access can be outstanding at a time. The core sees this through a ready output. An access that is not aligned is never trapped. Its low address bits are cleared instead.

Top module: `lsAlignUnit`

## Requirements
- R1: After reset, opReady is 1, memReq and ioReq are 0 and rdWe is 0. An instruction is accepted on a rising edge where opValid and opReady are both 1. opReady is 0 from the cycle after a memory or I/O access is accepted until that access completes.
- R2: instr[5:3] = 3'b100 selects the load group and 3'b101 selects the store group. instr[2:0] is the sub-op. The effective address is rsA plus instr[31:16] sign-extended to 32 bits. The destination index rdIdx is instr[10:6]. memWe/ioWe is 1 for a store and 0 for a load.
- R3: Load sub-op 0 and store sub-op 0 are word accesses, and they clear address bits 1:0. Load sub-ops 1 and 5 and store sub-op 1 are halfword accesses, and they clear address bit 0. Load sub-ops 2 and 6 and store sub-op 2 are byte accesses, and they keep the address unchanged.
- R4: The memory is little-endian. For a store, memBe is 4'b1111 for a word. For a halfword it is 4'b0011, or 4'b1100 when address bit 1 is set. For a byte it is the one-hot bit at address bits 1:0. memWdata holds rsB for a word, rsB[15:0] twice for a halfword and rsB[7:0] four times for a byte.
- R5: A load returns the lane selected by the aligned address, meaning bits 8*addr[1:0] and up. Sub-ops 1 and 2 sign-extend the value. Sub-ops 5 and 6 zero-extend it. Sub-op 0 returns the whole word.
- R6: Load sub-op 3 and store sub-op 3 use the I/O port as word accesses at a word-aligned address. ioWdata is rsB. memReq stays 0 during these accesses, and memReq and ioReq are never both 1.
- R7: Load sub-op 4 writes {instr[31:16], 16'h0}. Load sub-op 7 writes pcIn + 4 + {instr[31:16], 16'h0}. Both raise rdWe in the cycle after acceptance, for one cycle, and neither makes a request.
- R8: A request rises in the cycle after acceptance and stays high until the matching rvalid is sampled, then drops in the next cycle. A load raises rdWe for one cycle, in the cycle after rvalid is sampled. A store never raises rdWe.
- R9: An rvalid on a port with no outstanding request on that port is ignored. It raises no rdWe and completes no access.
- R10: Opcode groups other than load and store, and store sub-ops 4 to 7, are ignored. They make no request, raise no rdWe and leave opReady at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An instruction is presented |
| opReady | output | 1 | Unit can accept an instruction |
| instr | input | 32 | Instruction word |
| rsA | input | 32 | Base register value |
| rsB | input | 32 | Store data register value |
| pcIn | input | 32 | Program counter of the instruction |
| memReq | output | 1 | Memory request outstanding |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Aligned memory address |
| memBe | output | 4 | Memory byte-lane enables |
| memWdata | output | 32 | Lane-replicated store data |
| memRvalid | input | 1 | Memory response, read data valid |
| memRdata | input | 32 | Memory read word |
| ioReq | output | 1 | I/O request outstanding |
| ioWe | output | 1 | I/O request is a write |
| ioAddr | output | 32 | Word-aligned I/O address |
| ioWdata | output | 32 | I/O write data |
| ioRvalid | input | 1 | I/O response, read data valid |
| ioRdata | input | 32 | I/O read word |
| rdWe | output | 1 | Destination register write strobe |
| rdIdx | output | 5 | Destination register index |
| rdData | output | 32 | Destination register value |

## Verification
The hardest case to reach is a response that arrives on the wrong port while an access is still outstanding on the other port. A memory rvalid during an I/O read must neither finish the read nor raise a write. To set this up, the bench gives the I/O responder a fixed wait of several cycles. It then injects a lone memory rvalid pulse in the first of those cycles and checks that ioReq is still held. The bench also walks every sign- and zero-extending load across all four lane offsets of words whose lanes have the top bit set and clear in turn.

// File: rtl/lsauPkg.sv
package lsauPkg;
  localparam int DATA_W  = 32;
  localparam int IMM_W   = 16;
  localparam int REG_W   = 5;
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int PC_STEP = 4;

  localparam logic [2:0] GRP_LOAD  = 3'b100;
  localparam logic [2:0] GRP_STORE = 3'b101;

  typedef enum logic [1:0] {SZ_WORD, SZ_HALF, SZ_BYTE} accSize_e;

  typedef struct packed {
    logic     capture;   // launch memory/io access, latch address and lanes
    logic     ioSel;     // access targets the io port
    logic     immWrite;  // upper-immediate result written directly
    logic     immPcRel;  // add pc + step to the upper immediate
    logic     loadDone;  // load response accepted this cycle
    accSize_e size;
    logic     signExt;
  } lsStrobe_t;
endpackage

// File: rtl/lsauCtrl.sv
module lsauCtrl
  import lsauPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [5:0] opField,
  input  logic       memRvalid,
  input  logic       ioRvalid,
  output logic       opReady,
  output logic       memReq,
  output logic       memWe,
  output logic       ioReq,
  output logic       ioWe,
  output lsStrobe_t  strobe
);
  logic [2:0] grp, sub;
  logic       memOp, ioOp, immOp, pcRel, storeOp, sext;
  accSize_e   size;
  logic       busyQ, ioQ, weQ;
  logic       accept, launch, respIn, done;

  assign grp = opField[5:3];
  assign sub = opField[2:0];

  always_comb begin
    memOp = 1'b0; ioOp = 1'b0; immOp = 1'b0; pcRel = 1'b0;
    storeOp = 1'b0; sext = 1'b0; size = SZ_WORD;
    if (grp == GRP_LOAD) begin
      unique case (sub)
        3'd0: memOp = 1'b1;
        3'd1: begin memOp = 1'b1; size = SZ_HALF; sext = 1'b1; end
        3'd2: begin memOp = 1'b1; size = SZ_BYTE; sext = 1'b1; end
        3'd3: ioOp = 1'b1;
        3'd4: immOp = 1'b1;
        3'd5: begin memOp = 1'b1; size = SZ_HALF; end
        3'd6: begin memOp = 1'b1; size = SZ_BYTE; end
        default: begin immOp = 1'b1; pcRel = 1'b1; end
      endcase
    end else if (grp == GRP_STORE) begin
      storeOp = 1'b1;
      case (sub)
        3'd0: memOp = 1'b1;
        3'd1: begin memOp = 1'b1; size = SZ_HALF; end
        3'd2: begin memOp = 1'b1; size = SZ_BYTE; end
        3'd3: ioOp = 1'b1;
        default: storeOp = 1'b0;
      endcase
    end
  end

  assign accept = opValid && !busyQ;
  assign launch = accept && (memOp || ioOp);
  assign respIn = ioQ ? ioRvalid : memRvalid;
  assign done   = busyQ && respIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      ioQ   <= 1'b0;
      weQ   <= 1'b0;
    end else if (launch) begin
      busyQ <= 1'b1;
      ioQ   <= ioOp;
      weQ   <= storeOp;
    end else if (done) begin
      busyQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.capture  = launch;
    strobe.ioSel    = ioOp;
    strobe.immWrite = accept && immOp;
    strobe.immPcRel = pcRel;
    strobe.loadDone = done && !weQ;
    strobe.size     = size;
    strobe.signExt  = sext;
  end

  assign opReady = !busyQ;
  assign memReq  = busyQ && !ioQ;
  assign ioReq   = busyQ && ioQ;
  assign memWe   = memReq && weQ;
  assign ioWe    = ioReq && weQ;

  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && ioReq));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> memReq);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> (!memReq && !ioReq));
  // R7
  imm_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.immWrite |=> (!memReq && !ioReq));
endmodule

// File: rtl/lsauDatapath.sv
module lsauDatapath
  import lsauPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lsStrobe_t         strobe,
  input  logic [IMM_W-1:0]  immField,
  input  logic [REG_W-1:0]  rdField,
  input  logic [DATA_W-1:0] rsA,
  input  logic [DATA_W-1:0] rsB,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic [DATA_W-1:0] reqAddr,
  output logic [LANES-1:0]  reqBe,
  output logic [DATA_W-1:0] reqWdata,
  output logic              rdWe,
  output logic [REG_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] effAddr, alignedAddr, byteRep, halfRep, laneWdata;
  logic [LANES-1:0]  byteBe, halfBe, laneBe;
  logic [OFF_W-1:0]  lane;
  logic [DATA_W-1:0] rawData, laneShift, loadVal, immVal;

  logic [DATA_W-1:0] addrQ, wdataQ, rdDataQ;
  logic [LANES-1:0]  beQ;
  accSize_e          sizeQ;
  logic              sextQ, ioSelQ, rdWeQ;
  logic [REG_W-1:0]  rdIdxQ;

  assign effAddr = rsA + {{EXT_W{immField[IMM_W-1]}}, immField};

  always_comb begin
    case (strobe.size)
      SZ_WORD: alignedAddr = {effAddr[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
      SZ_HALF: alignedAddr = {effAddr[DATA_W-1:1], 1'b0};
      default: alignedAddr = effAddr;
    endcase
  end

  assign lane = alignedAddr[OFF_W-1:0];

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign byteRep[gl*8 +: 8] = rsB[7:0];
    assign halfRep[gl*8 +: 8] = rsB[(gl%2)*8 +: 8];
    assign byteBe[gl] = (lane == OFF_W'(gl));
    assign halfBe[gl] = (lane[OFF_W-1:1] == (OFF_W-1)'(gl/2));
  end

  always_comb begin
    case (strobe.size)
      SZ_WORD: begin laneBe = '1;     laneWdata = rsB;     end
      SZ_HALF: begin laneBe = halfBe; laneWdata = halfRep; end
      default: begin laneBe = byteBe; laneWdata = byteRep; end
    endcase
  end

  assign rawData   = ioSelQ ? ioRdata : memRdata;
  assign laneShift = rawData >> {addrQ[OFF_W-1:0], 3'b000};

  always_comb begin
    case (sizeQ)
      SZ_WORD: loadVal = rawData;
      SZ_HALF: loadVal = {{(DATA_W-16){sextQ & laneShift[15]}}, laneShift[15:0]};
      default: loadVal = {{(DATA_W-8){sextQ & laneShift[7]}}, laneShift[7:0]};
    endcase
  end

  assign immVal = {immField, {EXT_W{1'b0}}}
                + (strobe.immPcRel ? pcIn + DATA_W'(PC_STEP) : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      beQ     <= '1;
      wdataQ  <= '0;
      sizeQ   <= SZ_WORD;
      sextQ   <= 1'b0;
      ioSelQ  <= 1'b0;
      rdWeQ   <= 1'b0;
      rdIdxQ  <= '0;
      rdDataQ <= '0;
    end else begin
      rdWeQ <= strobe.loadDone || strobe.immWrite;
      if (strobe.capture) begin
        addrQ  <= alignedAddr;
        beQ    <= laneBe;
        wdataQ <= laneWdata;
        sizeQ  <= strobe.size;
        sextQ  <= strobe.signExt;
        ioSelQ <= strobe.ioSel;
        rdIdxQ <= rdField;
      end
      if (strobe.immWrite) begin
        rdDataQ <= immVal;
        rdIdxQ  <= rdField;
      end else if (strobe.loadDone) begin
        rdDataQ <= loadVal;
      end
    end
  end

  assign reqAddr  = addrQ;
  assign reqBe    = beQ;
  assign reqWdata = wdataQ;
  assign rdWe     = rdWeQ;
  assign rdIdx    = rdIdxQ;
  assign rdData   = rdDataQ;

  // R8
  wr_after_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWe |-> $past(strobe.loadDone || strobe.immWrite));
  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&reqBe) || $onehot(reqBe) || reqBe == LANES'(3) || reqBe == LANES'(12));
  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&reqBe) |-> reqAddr[OFF_W-1:0] == '0);
endmodule

// File: rtl/lsAlignUnit.sv
module lsAlignUnit
  import lsauPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] rsA,
  input  logic [DATA_W-1:0] rsB,
  input  logic [DATA_W-1:0] pcIn,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ioReq,
  output logic              ioWe,
  output logic [DATA_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic              ioRvalid,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              rdWe,
  output logic [REG_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  lsStrobe_t         strobe;
  logic [DATA_W-1:0] reqAddr, reqWdata;

  lsauCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opField(instr[5:0]),
    .memRvalid(memRvalid), .ioRvalid(ioRvalid), .opReady(opReady),
    .memReq(memReq), .memWe(memWe), .ioReq(ioReq), .ioWe(ioWe),
    .strobe(strobe)
  );

  lsauDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .immField(instr[DATA_W-1:DATA_W-IMM_W]), .rdField(instr[10:6]),
    .rsA(rsA), .rsB(rsB), .pcIn(pcIn),
    .memRdata(memRdata), .ioRdata(ioRdata),
    .reqAddr(reqAddr), .reqBe(memBe), .reqWdata(reqWdata),
    .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData)
  );

  assign memAddr  = reqAddr;
  assign ioAddr   = reqAddr;
  assign memWdata = reqWdata;
  assign ioWdata  = reqWdata;
endmodule

// File: tb/lsAlignUnit_tb_top.sv
`timescale 1ns/1ps
module lsAlignUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [31:0] instr = '0, rsA = '0, rsB = '0, pcIn = '0;
  logic        memReq, memWe, ioReq, ioWe, rdWe;
  logic [31:0] memAddr, memWdata, ioAddr, ioWdata, rdData;
  logic [3:0]  memBe;
  logic [4:0]  rdIdx;
  logic        memRespV = 1'b0, ioRespV = 1'b0, spurV = 1'b0;
  logic        memRvalid, ioRvalid;
  logic [31:0] memRdata = '0, ioRdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  logic [31:0] mem [16];
  logic [31:0] ioRegs [4];
  int memWait = 0, latCnt = 0, ioWait = 0;

  assign memRvalid = memRespV | spurV;
  assign ioRvalid  = ioRespV;

  always #10 clk = ~clk;

  lsAlignUnit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .instr(instr), .rsA(rsA), .rsB(rsB), .pcIn(pcIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata),
    .ioReq(ioReq), .ioWe(ioWe), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioRvalid(ioRvalid), .ioRdata(ioRdata),
    .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- responders ----------------
  always @(negedge clk) begin
    if (!rstN) begin
      memRespV <= 1'b0; ioRespV <= 1'b0; memWait <= 0; ioWait <= 0;
    end else begin
      memRespV <= 1'b0;
      ioRespV  <= 1'b0;
      if (memReq && !memRespV) begin
        if (memWait == 0) begin
          memRespV <= 1'b1;
          memRdata <= mem[memAddr[5:2]];
          if (memWe)
            for (int l = 0; l < 4; l++)
              if (memBe[l]) mem[memAddr[5:2]][l*8 +: 8] = memWdata[l*8 +: 8];
          memWait <= latCnt % 3;
          latCnt  <= latCnt + 1;
        end else memWait <= memWait - 1;
      end
      if (ioReq && !ioRespV) begin
        if (ioWait == 3) begin
          ioRespV <= 1'b1;
          ioRdata <= ioRegs[ioAddr[3:2]];
          if (ioWe) ioRegs[ioAddr[3:2]] = ioWdata;
          ioWait <= 0;
        end else ioWait <= ioWait + 1;
      end
    end
  end

  // ---------------- reference model ----------------
  bit          mBusy = 0, mIo = 0, mStore = 0, mSgn = 0, mRdWe = 0;
  int          mSz = 4;
  logic [31:0] mAddr = '0, mWdata = '0, mRdData = '0;
  logic [3:0]  mBe = '1;
  logic [4:0]  mRdIdx = '0;
  string       mTag = "R5";

  function automatic logic [31:0] expExt(logic [31:0] raw, int sz, bit sgn, logic [31:0] a);
    logic [31:0] m;
    int sh = int'(a % 4) * 8;
    if (sz == 4) return raw;
    m = (raw >> sh) & ((sz == 2) ? 32'hFFFF : 32'hFF);
    if (sgn && m >= ((sz == 2) ? 32'h8000 : 32'h80))
      m = m - ((sz == 2) ? 32'h10000 : 32'h100);
    return m;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] ea, up;
    logic [2:0]  g, s;
    int          sz;
    bit          go, io, st, sg;
    if (!rstN) begin
      mBusy <= 0; mRdWe <= 0;
    end else begin
      mRdWe <= 0;
      if (mBusy) begin
        if (mIo ? ioRvalid : memRvalid) begin
          mBusy <= 0;
          if (!mStore) begin
            mRdWe   <= 1;
            mRdData <= expExt(mIo ? ioRdata : memRdata, mSz, mSgn, mAddr);
            mTag    <= mIo ? "R6" : "R5";
          end
        end
      end else if (opValid) begin
        g  = instr[5:3]; s = instr[2:0];
        ea = rsA + 32'($signed(instr[31:16]));
        up = {instr[31:16], 16'h0};
        go = 0; io = 0; st = 0; sg = 0; sz = 4;
        if (g == 3'b100) begin
          if (s == 3'd4 || s == 3'd7) begin
            mRdWe   <= 1;
            mRdData <= (s == 3'd7) ? pcIn + 4 + up : up;
            mRdIdx  <= instr[10:6];
            mTag    <= "R7";
          end else begin
            go = 1; io = (s == 3'd3);
            sz = (s == 3'd1 || s == 3'd5) ? 2 : (s == 3'd2 || s == 3'd6) ? 1 : 4;
            sg = (s == 3'd1 || s == 3'd2);
          end
        end else if (g == 3'b101 && s < 3'd4) begin
          go = 1; st = 1; io = (s == 3'd3);
          sz = (s == 3'd1) ? 2 : (s == 3'd2) ? 1 : 4;
        end
        if (go) begin
          ea      = ea & ~32'(sz - 1);
          mBusy  <= 1; mIo <= io; mStore <= st; mSz <= sz; mSgn <= sg;
          mAddr  <= ea;
          mRdIdx <= instr[10:6];
          mBe    <= (sz == 4) ? 4'hF : (4'((sz == 2) ? 3 : 1) << ea[1:0]);
          mWdata <= (sz == 4) ? rsB : (sz == 2) ? rsB[15:0] * 32'h00010001
                                                : rsB[7:0] * 32'h01010101;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && started) begin
      chk("R1 opReady", 32'(opReady), 32'(!mBusy));
      chk("R8 memReq", 32'(memReq), 32'(mBusy && !mIo));
      chk("R6 ioReq", 32'(ioReq), 32'(mBusy && mIo));
      if (memReq) begin
        chk("R3 memAddr", memAddr, mAddr);
        chk("R2 memWe", 32'(memWe), 32'(mStore));
        if (memWe) begin
          chk("R4 memBe", 32'(memBe), 32'(mBe));
          chk("R4 memWdata", memWdata, mWdata);
        end
      end
      if (ioReq) begin
        chk("R6 ioAddr", ioAddr, mAddr);
        chk("R2 ioWe", 32'(ioWe), 32'(mStore));
        if (ioWe) chk("R6 ioWdata", ioWdata, mWdata);
      end
      chk("R8 rdWe", 32'(rdWe), 32'(mRdWe));
      if (rdWe && mRdWe) begin
        chk({mTag, " rdData"}, rdData, mRdData);
        chk("R2 rdIdx", 32'(rdIdx), 32'(mRdIdx));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mkLd(int sub, logic [15:0] imm, logic [4:0] rt);
    return {imm, 5'd1, rt, 3'b100, 3'(sub)};
  endfunction
  function automatic logic [31:0] mkSt(int sub, logic [15:0] imm);
    return {imm, 5'd1, 5'd2, 3'b101, 3'(sub)};
  endfunction

  task automatic issue(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pc);
    @(negedge clk);
    opValid = 1'b1; instr = i; rsA = a; rsB = b; pcIn = pc;
    while (!opReady) @(negedge clk);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic waitRd(output logic [31:0] got);
    while (!rdWe) @(negedge clk);
    got = rdData;
  endtask

  task automatic waitIdle();
    while (!opReady) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    int subs [5] = '{0, 1, 2, 5, 6};
    for (int k = 0; k < 16; k++) mem[k] = '0;
    mem[0] = 32'h80FF7F01;
    mem[1] = 32'h7F8001FE;
    for (int k = 0; k < 4; k++) ioRegs[k] = 32'h0BADF000 + 32'(k);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset opReady", 32'(opReady), 32'd1);
    chk("R1 reset memReq", 32'(memReq), 32'd0);
    chk("R1 reset ioReq", 32'(ioReq), 32'd0);
    chk("R1 reset rdWe", 32'(rdWe), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    started = 1;

    // R5 directed extension cases
    issue(mkLd(2, 16'hFF00, 5'd3), 32'h102, 0, 0); waitRd(got);
    chk("R5 ldb signed lane2", got, 32'hFFFFFFFF);
    issue(mkLd(6, 16'hFF00, 5'd3), 32'h102, 0, 0); waitRd(got);
    chk("R5 ldbu lane2", got, 32'h000000FF);
    issue(mkLd(1, 16'hFF00, 5'd4), 32'h103, 0, 0); waitRd(got);
    chk("R3 R5 ldh misaligned upper", got, 32'hFFFF80FF);
    issue(mkLd(0, 16'h0003, 5'd5), 32'h4, 0, 0); waitRd(got);
    chk("R3 ldw misaligned", got, 32'h7F8001FE);

    // R5 sweep of every extending load over all lanes, back to back
    for (int w = 0; w < 2; w++)
      for (int off = 0; off < 4; off++)
        for (int j = 0; j < 5; j++)
          issue(mkLd(subs[j], 16'hFF00, 5'(j + off)), 32'h100 + 32'(w * 4 + off), 0, 0);
    waitIdle();

    // R4 stores
    issue(mkSt(0, 16'h0000), 32'h10, 32'h11223344, 0);
    issue(mkSt(1, 16'h0000), 32'h13, 32'hAAAABEEF, 0);
    issue(mkSt(2, 16'hFFF1), 32'h20, 32'h0000005A, 0);
    issue(mkSt(0, 16'h0000), 32'h17, 32'hCAFEF00D, 0);
    issue(mkSt(2, 16'h0000), 32'h1B, 32'h12345677, 0);
    issue(mkSt(1, 16'h0000), 32'h1D, 32'h0000C3D2, 0);
    waitIdle();
    chk("R4 word+half+byte merge", mem[4], 32'hBEEF5A44);
    chk("R3 R4 misaligned word store", mem[5], 32'hCAFEF00D);
    chk("R4 byte lane3", mem[6], 32'h77000000);
    chk("R4 half lower lane", mem[7], 32'h0000C3D2);
    for (int off = 0; off < 4; off++)
      for (int j = 0; j < 5; j++)
        issue(mkLd(subs[j], 16'h0000, 5'd9), 32'h10 + 32'(off), 0, 0);
    waitIdle();

    // R6 io port
    issue(mkLd(3, 16'h0000, 5'd7), 32'h6, 0, 0);
    spurV = 1'b1;               // R9 memory rvalid during io read
    @(negedge clk);
    spurV = 1'b0;
    chk("R9 io read held past stray mem rvalid", 32'(ioReq), 32'd1);
    chk("R9 no write from stray rvalid", 32'(rdWe), 32'd0);
    waitRd(got);
    chk("R6 ldx data", got, 32'h0BADF001);
    issue(mkSt(3, 16'h0000), 32'hB, 32'h12345678, 0);
    waitIdle();
    chk("R6 stx reg", ioRegs[2], 32'h12345678);
    chk("R6 stx untouched mem", mem[2], 32'h0);

    // R7 upper immediates
    issue(mkLd(4, 16'h1234, 5'd11), 0, 0, 0); waitRd(got);
    chk("R7 lui", got, 32'h12340000);
    chk("R7 lui rdIdx", 32'(rdIdx), 32'd11);
    issue(mkLd(7, 16'hFFFF, 5'd12), 0, 0, 32'h1000); waitRd(got);
    chk("R7 auipc", got, 32'hFFFF1004);
    waitIdle();

    // R9 stray rvalid while idle
    @(negedge clk); spurV = 1'b1;
    @(negedge clk); spurV = 1'b0;
    chk("R9 idle stray rdWe", 32'(rdWe), 32'd0);
    chk("R9 idle stray opReady", 32'(opReady), 32'd1);

    // R10 ignored encodings
    issue(32'h00001008, 32'h10, 32'hFFFFFFFF, 0);
    chk("R10 other group memReq", 32'(memReq | ioReq), 32'd0);
    chk("R10 other group rdWe", 32'(rdWe), 32'd0);
    issue(mkSt(5, 16'h0000), 32'h10, 32'hFFFFFFFF, 0);
    chk("R10 undefined store memReq", 32'(memReq | ioReq), 32'd0);
    chk("R10 undefined store opReady", 32'(opReady), 32'd1);
    waitIdle();
    chk("R10 memory untouched", mem[4], 32'hBEEF5A44);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule